// File: doc/BRIEF.md
# Gate Drive Mode Sequencer with Bootstrap Pre-Charge

This block decides the operating mode of a three-phase gate pre-driver. Four comparator flags describe the control voltage. In rising order they say that it is above the power-save level, above the run level, above the start level and above the test level. Two active-low inputs report an external power-stage fault and an over-temperature thermistor. From these the block moves between six modes: power-save, standby, bootstrap pre-charge, drive, test and halt. It exposes the mode on a 3-bit code.

The block takes high-side and low-side gate requests from an upstream commutation and PWM stage. It passes them to the six gate outputs only in drive and test modes. In every other mode it generates the gate pattern itself. In standby it fires short periodic pulses on all low-side switches so that the bootstrap capacitors stay charged. Before drive it holds all low sides on for a fixed pre-charge time. Each phase passes through a dead-band stage so that its two switches are never on together and never switch over without an idle gap. Every duration is a clock-cycle parameter.

Top module: `gdrv_seq`

## Requirements
- R1: While `lvl_save` is low, all six gate outputs are low in the same cycle. After the next clock edge the mode is power-save and `bias_en` is low. This takes priority over every other input. In every other mode `bias_en` is high.
- R2: Mode codes are 0 power-save, 1 standby, 2 pre-charge, 3 drive, 4 test and 5 halt. Reset gives mode 0 with all outputs low.
- R3: In standby all high-side outputs stay low. All three low-side outputs pulse high for `PULSE_CYC` cycles at the start of every `PERIOD_CYC`-cycle window, counted from entry into standby.
- R4: Leaving standby or halt needs `lvl_start`. Once in drive or test, the mode holds as long as `lvl_run` stays high, even if `lvl_start` drops. When `lvl_run` drops, the mode returns to standby.
- R5: Pre-charge lasts exactly `PRECHG_CYC` cycles, with high sides low and all low sides high. It then enters drive, or test if `lvl_test` is high. If `lvl_start` drops during pre-charge, the mode goes back to standby.
- R6: A low `fault_n` or `therm_n` forces all six gate outputs low in the same cycle. After the next edge the mode is halt (5).
- R7: When both trip inputs are high again and `lvl_start` is high, halt goes straight to pre-charge. Without `lvl_start` it goes to standby.
- R8: In drive, `lvl_test` high selects test mode (4). Test mode returns to drive when `lvl_test` drops. In both modes the gates follow the requests.
- R9: A gate output of a phase only turns on after the opposite output of that phase has been low for at least `DEAD_CYC` cycles.
- R10: In drive or test, each gate output follows its request with one cycle of latency. A phase that requests both sides at once gets neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_save | input | 1 | Control voltage above power-save level |
| lvl_run | input | 1 | Control voltage above the hold-drive level |
| lvl_start | input | 1 | Control voltage above the start-from-stop level |
| lvl_test | input | 1 | Control voltage above the test level |
| fault_n | input | 1 | Power-stage fault, active low |
| therm_n | input | 1 | Over-temperature, active low |
| hs_req | input | NPH | High-side gate requests from the PWM stage |
| ls_req | input | NPH | Low-side gate requests from the PWM stage |
| hs_gate | output | NPH | High-side gate commands |
| ls_gate | output | NPH | Low-side gate commands |
| bias_en | output | 1 | Sensor bias supply enable |
| mode | output | 3 | Current mode code |

## Verification
Two situations are the hardest to reach from the ports. The first is a trip that arrives while the dead-band stages are part-way through a gap. The second is a control level that falls between the run and start flags while the block sits in pre-charge or halt. Directed sequences cover the standby pulse train, the exact pre-charge length, the hysteresis and the trip recovery. A long seeded random run then mixes slowly drifting control levels, one-cycle trip pulses and fast-changing gate requests, so that mode changes land at arbitrary points in the timer and dead-band counts. A cycle-level bench model predicts every output, and a gap monitor measures the dead time at each rising gate.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  typedef enum logic [2:0] {
    M_SAVE   = 3'd0,
    M_STBY   = 3'd1,
    M_PRECHG = 3'd2,
    M_DRIVE  = 3'd3,
    M_TEST   = 3'd4,
    M_HALT   = 3'd5
  } mode_t;
endpackage

// File: rtl/gdrv_mode_fsm.sv
module gdrv_mode_fsm
  import gdrv_pkg::*;
#(
  parameter int unsigned PULSE_CYC  = 500,
  parameter int unsigned PERIOD_CYC = 4000,
  parameter int unsigned PRECHG_CYC = 910000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lvl_save,
  input  logic  lvl_run,
  input  logic  lvl_start,
  input  logic  lvl_test,
  input  logic  trip,
  output mode_t state,
  output logic  boot_pulse
);
  localparam int unsigned TMAX = (PRECHG_CYC > PERIOD_CYC) ? PRECHG_CYC : PERIOD_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PRE_LAST = TW'(PRECHG_CYC - 1);
  localparam logic [TW-1:0] PER_LAST = TW'(PERIOD_CYC - 1);
  localparam logic [TW-1:0] PULSE_W  = TW'(PULSE_CYC);
  localparam logic [TW-1:0] T_SAT    = TW'(TMAX);

  mode_t         st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  // next mode: power-save beats trips, trips beat the level flags
  always_comb begin
    st_d = state;
    if (!lvl_save)  st_d = M_SAVE;
    else if (trip)  st_d = M_HALT;
    else begin
      case (state)
        M_SAVE:   st_d = M_STBY;
        M_STBY,
        M_HALT:   st_d = lvl_start ? M_PRECHG : M_STBY;
        M_PRECHG: begin
          if (!lvl_start)            st_d = M_STBY;
          else if (tmr_q == PRE_LAST) st_d = lvl_test ? M_TEST : M_DRIVE;
        end
        M_DRIVE:  begin
          if (!lvl_run)      st_d = M_STBY;
          else if (lvl_test) st_d = M_TEST;
        end
        M_TEST:   begin
          if (!lvl_run)       st_d = M_STBY;
          else if (!lvl_test) st_d = M_DRIVE;
        end
        default:  st_d = M_SAVE;
      endcase
    end
  end

  // shared interval timer: restarts on every mode change and wraps in standby
  always_comb begin
    tmr_en = 1'b1;
    tmr_d  = tmr_q + 1'b1;
    if (st_d != state)                              tmr_d = '0;
    else if (state == M_STBY && tmr_q == PER_LAST)  tmr_d = '0;
    else if (tmr_q == T_SAT)                        tmr_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= M_SAVE;
      tmr_q <= '0;
    end else begin
      state <= st_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign boot_pulse = (state == M_STBY) && (tmr_q < PULSE_W);
endmodule

// File: rtl/gdrv_deadband.sv
module gdrv_deadband #(
  parameter int unsigned DEAD_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi,
  input  logic want_lo,
  output logic hi_q,
  output logic lo_q
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEAD_CYC);

  logic [CW-1:0] idle_q, idle_d;
  logic          hi_d, lo_d, gap_ok, idle_en;

  always_comb begin
    gap_ok  = (idle_q == CMAX);
    hi_d    = want_hi && !want_lo && (hi_q || (!lo_q && gap_ok));
    lo_d    = want_lo && !want_hi && (lo_q || (!hi_q && gap_ok));
    idle_en = hi_q || lo_q || !gap_ok;
    idle_d  = (hi_q || lo_q) ? '0 : idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      idle_q <= CMAX;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      if (idle_en) idle_q <= idle_d;
    end
  end
endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq
  import gdrv_pkg::*;
#(
  parameter int unsigned NPH        = 3,
  parameter int unsigned DEAD_CYC   = 500,
  parameter int unsigned PULSE_CYC  = 500,
  parameter int unsigned PERIOD_CYC = 4000,
  parameter int unsigned PRECHG_CYC = 910000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lvl_save,
  input  logic           lvl_run,
  input  logic           lvl_start,
  input  logic           lvl_test,
  input  logic           fault_n,
  input  logic           therm_n,
  input  logic [NPH-1:0] hs_req,
  input  logic [NPH-1:0] ls_req,
  output logic [NPH-1:0] hs_gate,
  output logic [NPH-1:0] ls_gate,
  output logic           bias_en,
  output logic [2:0]     mode
);
  mode_t          state;
  logic           boot_pulse, trip, kill;
  logic [NPH-1:0] hi_r, lo_r;

  assign trip = !fault_n || !therm_n;
  assign kill = !lvl_save || trip;

  gdrv_mode_fsm #(
    .PULSE_CYC (PULSE_CYC),
    .PERIOD_CYC(PERIOD_CYC),
    .PRECHG_CYC(PRECHG_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_save  (lvl_save),
    .lvl_run   (lvl_run),
    .lvl_start (lvl_start),
    .lvl_test  (lvl_test),
    .trip      (trip),
    .state     (state),
    .boot_pulse(boot_pulse)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic wh, wl;
    always_comb begin
      wh = 1'b0;
      wl = 1'b0;
      case (state)
        M_STBY:         wl = boot_pulse;
        M_PRECHG:       wl = 1'b1;
        M_DRIVE, M_TEST: begin
          wh = hs_req[p] && !ls_req[p];
          wl = ls_req[p] && !hs_req[p];
        end
        default: ;
      endcase
    end

    gdrv_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .want_hi(wh),
      .want_lo(wl),
      .hi_q   (hi_r[p]),
      .lo_q   (lo_r[p])
    );
  end

  // trips and power-save cut the gates without waiting for the mode register
  assign hs_gate = hi_r & {NPH{!kill}};
  assign ls_gate = lo_r & {NPH{!kill}};
  assign bias_en = (state != M_SAVE);
  assign mode    = state;
endmodule

// File: rtl/gdrv_seq_chk.sv
module gdrv_seq_chk #(
  parameter int unsigned NPH      = 3,
  parameter int unsigned DEAD_CYC = 500
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lvl_save,
  input logic           lvl_run,
  input logic           lvl_test,
  input logic           fault_n,
  input logic           therm_n,
  input logic [NPH-1:0] hs_gate,
  input logic [NPH-1:0] ls_gate,
  input logic           bias_en,
  input logic [2:0]     mode
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEAD_CYC);

  assert_save_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_save |-> (hs_gate == '0 && ls_gate == '0));

  assert_save_bias_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_save |=> (!bias_en && mode == 3'd0));

  assert_mode_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd5);

  assert_stby_hs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd1 |=> (mode != 3'd1 || hs_gate == '0));

  assert_drive_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && lvl_save && lvl_run && !lvl_test && fault_n && therm_n) |=> mode == 3'd3);

  assert_prechg_hs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd2 |=> (mode != 3'd2 || hs_gate == '0));

  assert_trip_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n || !therm_n) |-> (hs_gate == '0 && ls_gate == '0));

  assert_trip_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_save && (!fault_n || !therm_n)) |=> mode == 3'd5);

  for (genvar p = 0; p < NPH; p++) begin : g_gap
    logic [CW-1:0] lo_idle, hi_idle;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_idle <= CMAX;
        hi_idle <= CMAX;
      end else begin
        if (ls_gate[p])          lo_idle <= '0;
        else if (lo_idle != CMAX) lo_idle <= lo_idle + 1'b1;
        if (hs_gate[p])          hi_idle <= '0;
        else if (hi_idle != CMAX) hi_idle <= hi_idle + 1'b1;
      end
    end

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate[p] && ls_gate[p]));

    assert_hs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate[p]) |-> lo_idle == CMAX);

    assert_ls_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate[p]) |-> hi_idle == CMAX);
  end
endmodule

bind gdrv_seq gdrv_seq_chk #(.NPH(NPH), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lvl_save(lvl_save),
  .lvl_run (lvl_run),
  .lvl_test(lvl_test),
  .fault_n (fault_n),
  .therm_n (therm_n),
  .hs_gate (hs_gate),
  .ls_gate (ls_gate),
  .bias_en (bias_en),
  .mode    (mode)
);

// File: tb/gdrv_seq_test.sv
`timescale 1ns/1ps
module gdrv_seq_test;
  localparam int DEAD   = 3;
  localparam int PULSE  = 4;
  localparam int PERIOD = 20;
  localparam int PRE    = 30;
  localparam int TMAX   = (PRE > PERIOD) ? PRE : PERIOD;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lvl_save, lvl_run, lvl_start, lvl_test, fault_n, therm_n;
  logic [2:0] hs_req, ls_req, hs_gate, ls_gate, mode;
  logic       bias_en;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, done = 0;

  always #2.5 clk = ~clk;

  gdrv_seq #(.NPH(3), .DEAD_CYC(DEAD), .PULSE_CYC(PULSE), .PERIOD_CYC(PERIOD), .PRECHG_CYC(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .lvl_save(lvl_save), .lvl_run(lvl_run), .lvl_start(lvl_start),
    .lvl_test(lvl_test), .fault_n(fault_n), .therm_n(therm_n), .hs_req(hs_req), .ls_req(ls_req),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .bias_en(bias_en), .mode(mode));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- expected-value model ----------------
  int m_st, m_tmr;
  int m_hi[3], m_lo[3], m_cnt[3];

  function automatic int next_mode(int st, int tmr, bit sv, bit rn, bit stt, bit ts, bit trip);
    if (!sv) return 0;
    if (trip) return 5;
    case (st)
      0: return 1;
      1, 5: return stt ? 2 : 1;
      2: return !stt ? 1 : (tmr == PRE - 1) ? (ts ? 4 : 3) : 2;
      3: return !rn ? 1 : ts ? 4 : 3;
      4: return !rn ? 1 : !ts ? 3 : 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit want_h(int st, bit hr, bit lr);
    return (st == 3 || st == 4) && hr && !lr;
  endfunction

  function automatic bit want_l(int st, int tmr, bit hr, bit lr);
    if (st == 1) return tmr < PULSE;
    if (st == 2) return 1'b1;
    return (st == 3 || st == 4) && lr && !hr;
  endfunction

  function automatic string tag_of(int st);
    case (st)
      0: return "R1";
      1: return "R3";
      2: return "R5";
      3: return "R10";
      4: return "R8";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tmr = 0;
      for (int i = 0; i < 3; i++) begin m_hi[i] = 0; m_lo[i] = 0; m_cnt[i] = DEAD; end
    end else begin
      int nx, nt;
      nx = next_mode(m_st, m_tmr, lvl_save, lvl_run, lvl_start, lvl_test, !fault_n || !therm_n);
      for (int i = 0; i < 3; i++) begin
        bit wh, wl, nh, nl;
        wh = want_h(m_st, hs_req[i], ls_req[i]);
        wl = want_l(m_st, m_tmr, hs_req[i], ls_req[i]);
        nh = wh && !wl && (m_hi[i] != 0 || (m_lo[i] == 0 && m_cnt[i] >= DEAD));
        nl = wl && !wh && (m_lo[i] != 0 || (m_hi[i] == 0 && m_cnt[i] >= DEAD));
        m_cnt[i] = (m_hi[i] != 0 || m_lo[i] != 0) ? 0 : (m_cnt[i] < DEAD ? m_cnt[i] + 1 : DEAD);
        m_hi[i] = nh; m_lo[i] = nl;
      end
      if (nx != m_st) nt = 0;
      else if (m_st == 1 && m_tmr == PERIOD - 1) nt = 0;
      else nt = (m_tmr < TMAX) ? m_tmr + 1 : m_tmr;
      m_st = nx; m_tmr = nt;
    end
  end

  // ---------------- per-cycle comparison and gap monitor ----------------
  bit [2:0] p_hs = '0, p_ls = '0;
  int lo_idle[3] = '{DEAD, DEAD, DEAD};
  int hi_idle[3] = '{DEAD, DEAD, DEAD};

  always @(negedge clk) begin
    if (mon_on) begin
      bit kill;
      int e_hs, e_ls;
      kill = !lvl_save || !fault_n || !therm_n;
      e_hs = 0; e_ls = 0;
      for (int i = 0; i < 3; i++) begin
        if (m_hi[i] != 0 && !kill) e_hs |= (1 << i);
        if (m_lo[i] != 0 && !kill) e_ls |= (1 << i);
      end
      chk("R2", "mode", int'(mode), m_st);
      chk(tag_of(m_st), "hs_gate", int'(hs_gate), e_hs);
      chk(tag_of(m_st), "ls_gate", int'(ls_gate), e_ls);
      chk("R1", "bias_en", int'(bias_en), int'(m_st != 0));
      for (int i = 0; i < 3; i++) begin
        if (hs_gate[i] && !p_hs[i]) chk("R9", "low-side idle before high rise", int'(lo_idle[i] >= DEAD), 1);
        if (ls_gate[i] && !p_ls[i]) chk("R9", "high-side idle before low rise", int'(hi_idle[i] >= DEAD), 1);
        lo_idle[i] = ls_gate[i] ? 0 : lo_idle[i] + 1;
        hi_idle[i] = hs_gate[i] ? 0 : hi_idle[i] + 1;
      end
      p_hs = hs_gate; p_ls = ls_gate;
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_lvl(input int v);
    lvl_save = (v >= 1); lvl_run = (v >= 2); lvl_start = (v >= 3); lvl_test = (v >= 4);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int cnt;
    void'($urandom(32'h1357_2468));
    rst_n = 0; set_lvl(0); fault_n = 1; therm_n = 1; hs_req = '0; ls_req = '0;
    cyc(1);
    mon_on = 1;
    cyc(3);
    @(negedge clk);
    chk("R2", "reset mode", int'(mode), 0);
    chk("R2", "reset gates", int'({hs_gate, ls_gate, bias_en}), 0);
    cyc(1); rst_n = 1;
    cyc(4);
    @(negedge clk);
    chk("R1", "bias off in power-save", int'(bias_en), 0);
    chk("R1", "mode power-save", int'(mode), 0);

    // R3: standby pulse train, counted over two windows
    set_lvl(1);
    cyc(1);
    cnt = 0;
    for (int k = 0; k < 2 * PERIOD; k++) begin
      @(negedge clk);
      if (ls_gate == 3'b111) cnt++;
      if (hs_gate != 0) chk("R3", "high side in standby", int'(hs_gate), 0);
    end
    chk("R3", "standby pulse cycles", cnt, 2 * PULSE);

    // R4: run level alone does not start
    set_lvl(2);
    cyc(10);
    @(negedge clk);
    chk("R4", "run level alone stays standby", int'(mode), 1);

    // R5: pre-charge length and pattern
    set_lvl(3);
    cyc(1);
    @(negedge clk);
    chk("R5", "enter pre-charge", int'(mode), 2);
    for (int k = 1; k < PRE; k++) begin
      cyc(1);
      @(negedge clk);
      if (k == 10) chk("R5", "pre-charge gates", int'({hs_gate, ls_gate}), 7);
      if (k == PRE - 1) chk("R5", "last pre-charge cycle", int'(mode), 2);
    end
    cyc(1);
    @(negedge clk);
    chk("R5", "pre-charge ends in drive", int'(mode), 3);

    // R10: requests pass after dead time; conflict yields off
    hs_req = 3'b001; ls_req = 3'b110;
    cyc(DEAD + 4);
    @(negedge clk);
    chk("R10", "drive hs follows", int'(hs_gate), 1);
    chk("R10", "drive ls follows", int'(ls_gate), 6);
    ls_req = 3'b111;
    cyc(2);
    @(negedge clk);
    chk("R10", "conflicting phase off", int'({hs_gate[0], ls_gate[0]}), 0);

    // R4: hysteresis holds drive on run level only
    set_lvl(2);
    cyc(5);
    @(negedge clk);
    chk("R4", "drive held below start level", int'(mode), 3);

    // R8: test mode
    set_lvl(4); hs_req = 3'b010; ls_req = 3'b101;
    cyc(1);
    @(negedge clk);
    chk("R8", "enter test", int'(mode), 4);
    cyc(DEAD + 4);
    @(negedge clk);
    chk("R8", "test gates follow", int'({hs_gate, ls_gate}), 6'b010101);
    set_lvl(3);
    cyc(1);
    @(negedge clk);
    chk("R8", "test back to drive", int'(mode), 3);

    // R6 / R7: trips
    fault_n = 0;
    @(negedge clk);
    chk("R6", "fault cuts gates same cycle", int'({hs_gate, ls_gate}), 0);
    cyc(1);
    @(negedge clk);
    chk("R6", "fault gives halt", int'(mode), 5);
    fault_n = 1;
    cyc(1);
    @(negedge clk);
    chk("R7", "fault clear re-enters pre-charge", int'(mode), 2);
    therm_n = 0;
    @(negedge clk);
    chk("R6", "thermistor cuts gates", int'({hs_gate, ls_gate}), 0);
    cyc(1);
    set_lvl(2); therm_n = 1;
    cyc(1);
    @(negedge clk);
    chk("R7", "clear without start goes standby", int'(mode), 1);
    therm_n = 0; set_lvl(0);
    cyc(1);
    @(negedge clk);
    chk("R1", "power-save beats trip", int'(mode), 0);
    therm_n = 1;

    // random phase
    set_lvl(3);
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 39) == 0) set_lvl($urandom_range(0, 4));
      fault_n = ($urandom_range(0, 299) != 0);
      therm_n = ($urandom_range(0, 299) != 0);
      if ($urandom_range(0, 5) == 0) begin
        hs_req = 3'($urandom_range(0, 7));
        ls_req = 3'($urandom_range(0, 7));
      end
      cyc(1);
    end
    @(negedge clk);
    finish_run();
  end
endmodule